// File: doc/BRIEF.md
# SPI Serial Flash Command Engine

A processor-facing controller that sends arbitrary byte commands to up to four SPI serial flash devices and collects their replies. Software uses a small 32-bit register bus with separate read and write strobes. It places up to four bytes in a transmit word, writes a command word that carries the transmit byte count, the receive byte count, a bank select and a go bit, and then polls a completion flag. The received bytes are then read from a receive word.

Two shortcut bits in the command word let the engine build common flash commands itself. One reads the device's status byte and copies it into the status register. The other sends the one-byte write-enable command. A separate mode register holds a software-access bit and a burst-write bit. The engine does not act on these bits; it only presents them on output pins for the memory-mapped access path elsewhere in the chip. The serial link always runs in SPI mode 3. The serial clock is the system clock divided by a fixed even parameter.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, all chip selects are high, `spi_sck` is high, `spi_mosi` is low, both mode outputs are low, and every register reads zero.
- R2: The registers sit at these byte addresses: mode 0x00, command 0x04, status 0x08, transmit 0x0C, receive 0x10. Read data appears on `bus_rdata` one clock after `bus_rd_en`. In the mode register, bit 28 drives `sw_mode_o` and bit 29 drives `burst_mode_o`. Both bits read back as written, and all other mode bits read zero.
- R3: The serial clock idles high. A transfer asserts the chip select DIV/2 system clocks before the first falling edge of the serial clock. Each half period of the serial clock lasts DIV/2 system clocks. `spi_mosi` changes only on falling edges. The chip select is released DIV/2 clocks after the last rising edge.
- R4: Setting command bit 7 sends the number of transmit bytes given in command bits [2:0]. The first byte sent is transmit bits [7:0], then bits [15:8], and so on. Each byte is sent most significant bit first.
- R5: After the transmit bytes, the engine clocks in the number of bytes given in command bits [6:4], with `spi_mosi` held low. The first received byte lands in receive bits [7:0], the second in [15:8] and the third in [23:16]. Receive bits [31:24] read zero, and the receive register is zeroed when each transfer starts.
- R6: Command bits [13:12] select which single `spi_cs_n` line is driven low during a transfer. No more than one line is ever low.
- R7: Setting command bit 10 sends opcode 0x05 and receives one byte. That byte is copied into status bits [7:0] and into the receive register. Status bits [7:0] change only through this command.
- R8: Setting command bit 11 sends the single opcode 0x06 and receives nothing. If several action bits are set, bit 10 wins over bit 11, and bit 11 wins over bit 7.
- R9: Status bit 8 sets when a transfer ends. It clears when the status register is written with bit 8 at 0. Writing bit 8 as 1 leaves it unchanged.
- R10: The action bits (7, 10, 11) of the command register clear themselves when the transfer starts. Writes to the command and transmit registers are ignored while a transfer is pending or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sw_mode_o | output | 1 | Software-access mode bit |
| burst_mode_o | output | 1 | Burst-write mode bit |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 4 | Active-low chip selects, one per bank |

## Verification
The assertions check the pin-level rules of SPI mode 3 on every cycle:
- at most one chip select is low;
- the clock is high whenever no chip select is low;
- `spi_mosi` holds still while the clock stays high;
- a chip select moves only while the clock is high.

They also check, on every cycle, that the mode outputs follow each mode write and that the top byte of a receive read is zero.

Some behaviour only the bench's scenarios can show. These are the exact waveform timing, the byte and bit order of each opcode, the packing of received bytes, the shortcut commands, and how the finished flag clears. They also include the lock-out of writes during a transfer. The bench compares the pins every clock against a waveform built from the requirements.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BANK_W = 2;
  localparam int NBANK  = 1 << BANK_W;

  localparam logic [ADDR_W-1:0] ADR_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_TXD  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_RXD  = 5'h10;

  localparam int MODE_SW_BIT    = 28;
  localparam int MODE_BURST_BIT = 29;
  localparam int CMD_GO_BIT     = 7;
  localparam int CMD_RDSR_BIT   = 10;
  localparam int CMD_WREN_BIT   = 11;
  localparam int CMD_BANK_LSB   = 12;
  localparam int STAT_DONE_BIT  = 8;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH} sh_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] tx;
    logic [2:0]        tx_bytes;
    logic [1:0]        rx_bytes;
    logic [BANK_W-1:0] bank;
  } xfer_req_t;
endpackage

// File: rtl/sfce_bank_decode.sv
module sfce_bank_decode
  import sfce_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  output logic [NBANK-1:0]  sel_n
);
  for (genvar i = 0; i < NBANK; i++) begin : g_sel
    assign sel_n[i] = (bank != BANK_W'(i));
  end
endmodule

// File: rtl/sfce_shifter.sv
module sfce_shifter
  import sfce_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx,
  input  logic [2:0]        tx_bytes,
  input  logic [1:0]        rx_bytes,
  input  logic [NBANK-1:0]  sel_n,
  input  logic              spi_miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [NBANK-1:0]  cs_n
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF - 1);

  sh_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [5:0]        k, nbits, txbits;
  logic [DATA_W-1:0] tx_q;
  logic [23:0]       rx_q;
  logic [4:0]        j;
  logic [2:0]        nbyte;
  logic              nxt_bit, tick;

  assign tick    = (cnt == '0);
  assign j       = k[4:0] - txbits[4:0];
  assign nbyte   = tx_bytes + {1'b0, rx_bytes};
  assign nxt_bit = (k < txbits) ? tx_q[{k[4:3], ~k[2:0]}] : 1'b0;
  assign busy    = (state != SH_IDLE);
  assign rx_word = {8'b0, rx_q};

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      state  <= SH_IDLE;
      cnt    <= '0;
      k      <= '0;
      nbits  <= '0;
      txbits <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck    <= 1'b1;
      mosi   <= 1'b0;
      cs_n   <= '1;
    end else begin
      case (state)
        SH_IDLE: if (start) begin
          state  <= SH_LEAD;
          cnt    <= RELOAD;
          cs_n   <= sel_n;
          mosi   <= 1'b0;
          tx_q   <= tx;
          txbits <= {tx_bytes, 3'b000};
          nbits  <= {nbyte, 3'b000};
          k      <= '0;
          rx_q   <= '0;
        end
        SH_LEAD: if (tick) begin
          sck   <= 1'b0;
          mosi  <= nxt_bit;
          cnt   <= RELOAD;
          state <= SH_LOW;
        end else cnt <= cnt - 1'b1;
        SH_LOW: if (tick) begin
          sck <= 1'b1;
          if (k >= txbits) rx_q[{j[4:3], ~j[2:0]}] <= spi_miso;
          k     <= k + 1'b1;
          cnt   <= RELOAD;
          state <= SH_HIGH;
        end else cnt <= cnt - 1'b1;
        SH_HIGH: if (tick) begin
          if (k == nbits) begin
            cs_n  <= '1;
            mosi  <= 1'b0;
            done  <= 1'b1;
            state <= SH_IDLE;
          end else begin
            sck   <= 1'b0;
            mosi  <= nxt_bit;
            cnt   <= RELOAD;
            state <= SH_LOW;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfce_regs.sv
module sfce_regs
  import sfce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [DATA_W-1:0] sh_rx,
  output logic              start,
  output xfer_req_t         req,
  output logic              sw_mode,
  output logic              burst_mode
);
  logic [2:0]        txlen_f, rxlen_f, tx_n;
  logic [1:0]        rx_n;
  logic              go_f, rdsr_f, wren_f, done_f, op_rdsr, act, lock;
  logic [BANK_W-1:0] bank_f;
  logic [DATA_W-1:0] tx_r, rx_r, rd_mux;
  logic [7:0]        sr_byte;

  assign act   = go_f | rdsr_f | wren_f;
  assign lock  = act | sh_busy | sh_done;
  assign start = act & ~sh_busy;

  always_comb begin
    if (txlen_f == 3'd0)     tx_n = 3'd1;
    else if (txlen_f > 3'd4) tx_n = 3'd4;
    else                     tx_n = txlen_f;
    rx_n = (rxlen_f > 3'd3) ? 2'd3 : rxlen_f[1:0];
    req.bank = bank_f;
    if (rdsr_f) begin
      req.tx = {24'b0, OP_RDSR}; req.tx_bytes = 3'd1; req.rx_bytes = 2'd1;
    end else if (wren_f) begin
      req.tx = {24'b0, OP_WREN}; req.tx_bytes = 3'd1; req.rx_bytes = 2'd0;
    end else begin
      req.tx = tx_r; req.tx_bytes = tx_n; req.rx_bytes = rx_n;
    end
  end

  always_comb begin
    case (addr)
      ADR_MODE: rd_mux = {2'b00, burst_mode, sw_mode, 28'b0};
      ADR_CMD:  rd_mux = {18'b0, bank_f, wren_f, rdsr_f, 2'b00, go_f, rxlen_f, 1'b0, txlen_f};
      ADR_STAT: rd_mux = {23'b0, done_f, sr_byte};
      ADR_TXD:  rd_mux = tx_r;
      ADR_RXD:  rd_mux = rx_r;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_mode <= 1'b0; burst_mode <= 1'b0;
      txlen_f <= '0; rxlen_f <= '0; bank_f <= '0;
      go_f <= 1'b0; rdsr_f <= 1'b0; wren_f <= 1'b0;
      tx_r <= '0; rx_r <= '0; sr_byte <= '0;
      done_f <= 1'b0; op_rdsr <= 1'b0; rdata <= '0;
    end else begin
      if (wr_en && addr == ADR_MODE) begin
        sw_mode    <= wdata[MODE_SW_BIT];
        burst_mode <= wdata[MODE_BURST_BIT];
      end
      if (wr_en && addr == ADR_CMD && !lock) begin
        txlen_f <= wdata[2:0];
        rxlen_f <= wdata[6:4];
        go_f    <= wdata[CMD_GO_BIT];
        rdsr_f  <= wdata[CMD_RDSR_BIT];
        wren_f  <= wdata[CMD_WREN_BIT];
        bank_f  <= wdata[CMD_BANK_LSB +: BANK_W];
      end
      if (wr_en && addr == ADR_TXD && !lock) tx_r <= wdata;
      if (start) begin
        go_f <= 1'b0; rdsr_f <= 1'b0; wren_f <= 1'b0;
        rx_r <= '0;
        op_rdsr <= rdsr_f;
      end
      if (wr_en && addr == ADR_STAT && !wdata[STAT_DONE_BIT]) done_f <= 1'b0;
      if (sh_done) begin
        done_f <= 1'b1;
        rx_r   <= sh_rx;
        if (op_rdsr) sr_byte <= sh_rx[7:0];
      end
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import sfce_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sw_mode_o,
  output logic              burst_mode_o,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NBANK-1:0]  spi_cs_n
);
  xfer_req_t         req;
  logic              start, sh_busy, sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic [NBANK-1:0]  sel_n;

  sfce_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .sh_busy(sh_busy), .sh_done(sh_done), .sh_rx(sh_rx),
    .start(start), .req(req), .sw_mode(sw_mode_o), .burst_mode(burst_mode_o)
  );

  sfce_bank_decode u_dec (.bank(req.bank), .sel_n(sel_n));

  sfce_shifter #(.DIV(DIV)) u_sh (
    .clk(clk), .rst(rst), .start(start), .tx(req.tx),
    .tx_bytes(req.tx_bytes), .rx_bytes(req.rx_bytes), .sel_n(sel_n),
    .spi_miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/sfce_checker.sv
module sfce_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr_en,
  input logic       bus_rd_en,
  input logic [4:0] bus_addr,
  input logic       wd_sw,
  input logic       wd_burst,
  input logic [7:0] rdata_top,
  input logic       sw_mode_o,
  input logic       burst_mode_o,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic [3:0] spi_cs_n
);
  // R6: at most one bank selected
  assert_cs_onehot0_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n));

  // R3: clock idles high
  assert_sck_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
    (&spi_cs_n) |-> spi_sck);

  // R3: data holds while the clock stays high inside a transfer
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck) && !(&spi_cs_n) && !(&$past(spi_cs_n)))
      |-> $stable(spi_mosi));

  // R3: chip select moves only during a high clock phase
  assert_cs_edge_sck_high_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> (spi_sck && $past(spi_sck)));

  // R2: mode outputs follow a mode write
  assert_mode_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == 5'h00)
      |=> (sw_mode_o == $past(wd_sw) && burst_mode_o == $past(wd_burst)));

  // R5: receive word top byte reads zero
  assert_rx_top_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == 5'h10) |=> (rdata_top == 8'h00));
endmodule

bind spi_flash_cmd_engine sfce_checker u_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .wd_sw(bus_wdata[28]), .wd_burst(bus_wdata[29]),
  .rdata_top(bus_rdata[31:24]), .sw_mode_o(sw_mode_o),
  .burst_mode_o(burst_mode_o), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n)
);

// File: tb/spi_flash_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam logic [5:0] IDLE_PINS = 6'b111110;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sw_mode_o, burst_mode_o, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs_n;

  spi_flash_cmd_engine #(.DIV(DIV)) uut (.*);

  always #2 clk = ~clk;

  int total = 0, fails = 0, pin_err = 0;
  bit finished = 0;
  logic [5:0] expq[$];
  logic [23:0] resp = '0;
  int cur_txbits = 0, fall_k = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pin model compared every clock
  always @(posedge clk) begin
    #1;
    if (!rst) begin : cmp
      logic [5:0] e;
      if (expq.size() > 0) e = expq.pop_front();
      else e = IDLE_PINS;
      if ({spi_cs_n, spi_sck, spi_mosi} !== e) pin_err++;
    end
  end

  // flash reply model: new bit after each falling clock edge
  always @(negedge spi_sck) begin : flash
    int jj;
    if (fall_k >= cur_txbits) begin
      jj = fall_k - cur_txbits;
      if (jj < 24) spi_miso = resp[(jj/8)*8 + 7 - (jj%8)];
    end
    fall_k++;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd_en = 1'b0; d = bus_rdata;
  endtask

  task automatic expect_xfer(input logic [31:0] tx, input int txb, input int rxb, input int bank);
    logic [3:0] csn;
    csn = ~(4'b0001 << bank);
    repeat (HALF) expq.push_back({csn, 2'b10});
    for (int k = 0; k < (txb + rxb) * 8; k++) begin
      logic b;
      b = (k < txb * 8) ? tx[(k/8)*8 + 7 - (k%8)] : 1'b0;
      repeat (HALF) expq.push_back({csn, 1'b0, b});
      repeat (HALF) expq.push_back({csn, 1'b1, b});
    end
  endtask

  task automatic run_cmd(input logic [31:0] cmd, input logic [31:0] tx_model,
                         input int txb, input int rxb, input int bank, input logic [23:0] r);
    resp = r; cur_txbits = txb * 8; fall_k = 0;
    wr(5'h04, cmd);
    expect_xfer(tx_model, txb, rxb, bank);
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pin_check(input string tag);
    check(tag, pin_err, 0);
    pin_err = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pins idle", {26'b0, spi_cs_n, spi_sck, spi_mosi}, {26'b0, IDLE_PINS});
    check("R1 mode outputs", {30'b0, burst_mode_o, sw_mode_o}, 0);
    rd(5'h00, d); check("R1 mode reg", d, 0);
    rd(5'h04, d); check("R1 command reg", d, 0);
    rd(5'h08, d); check("R1 status reg", d, 0);
    rd(5'h0C, d); check("R1 transmit reg", d, 0);
    rd(5'h10, d); check("R1 receive reg", d, 0);

    // R2 mode register
    wr(5'h00, 32'hFFFF_FFFF);
    check("R2 mode outputs both set", {30'b0, burst_mode_o, sw_mode_o}, 3);
    rd(5'h00, d); check("R2 mode readback masks", d, 32'h3000_0000);
    wr(5'h00, 32'h1000_0000);
    check("R2 mode sw only", {30'b0, burst_mode_o, sw_mode_o}, 1);

    // R4 R5 R6 identification read on bank 0
    wr(5'h0C, 32'h0000_009F);
    run_cmd(32'h0000_00B1, 32'h9F, 1, 3, 0, 24'h1520C2);
    wait_idle();
    pin_check("R3 R4 R6 id-read waveform");
    rd(5'h10, d); check("R5 receive packing", d, 32'h0015_20C2);
    rd(5'h04, d); check("R10 go bit self-cleared", d, 32'h0000_0031);

    // R4 R6 four-byte erase-style command on bank 2
    wr(5'h0C, 32'h5634_12D8);
    run_cmd(32'h0000_2084, 32'h5634_12D8, 4, 0, 2, 24'h0);
    wait_idle();
    pin_check("R4 R6 four-byte order on bank 2");
    rd(5'h08, d); check("R9 finished flag set", d, 32'h0000_0100);
    wr(5'h08, 32'h0);
    rd(5'h08, d); check("R9 flag cleared by zero", d, 32'h0);

    // R7 status shortcut on bank 1
    run_cmd(32'h0000_1400, 32'h05, 1, 1, 1, 24'h000003);
    wait_idle();
    pin_check("R7 status opcode waveform bank 1");
    rd(5'h08, d); check("R7 status byte mirrored", d, 32'h0000_0103);
    rd(5'h10, d); check("R7 status byte in receive", d, 32'h0000_0003);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); check("R9 write one keeps flag", d, 32'h0000_0103);
    wr(5'h08, 32'h0);
    rd(5'h08, d); check("R9 zero clears flag only", d, 32'h0000_0003);

    // R8 write-enable shortcut on bank 3
    run_cmd(32'h0000_3800, 32'h06, 1, 0, 3, 24'h0);
    wait_idle();
    pin_check("R8 write-enable waveform bank 3");
    rd(5'h08, d); check("R8 flag set, status byte kept", d, 32'h0000_0103);
    rd(5'h10, d); check("R5 receive zeroed at start", d, 32'h0);
    rd(5'h04, d); check("R10 shortcut bit self-cleared", d, 32'h0000_3000);

    // R8 priority: status read wins when bits 10 and 11 both set
    run_cmd(32'h0000_0C80, 32'h05, 1, 1, 0, 24'h000002);
    wait_idle();
    pin_check("R8 priority picks status read");
    rd(5'h08, d); check("R8 priority status byte", d, 32'h0000_0102);

    // R10 writes during a transfer are ignored
    wr(5'h0C, 32'h0000_00A5);
    run_cmd(32'h0000_0081, 32'hA5, 1, 0, 0, 24'h0);
    repeat (4) @(negedge clk);
    wr(5'h0C, 32'h1111_1111);
    wr(5'h04, 32'h0000_3081);
    wait_idle();
    repeat (40) @(negedge clk);
    pin_check("R10 no second transfer from busy write");
    rd(5'h0C, d); check("R10 transmit write ignored", d, 32'h0000_00A5);
    rd(5'h04, d); check("R10 command write ignored", d, 32'h0000_0001);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule